// File: doc/BRIEF.md
# Per-Bunch I/Q Phase Calculator

This block turns gated in-phase (I) and quadrature (Q) samples of a beam pick-up into one phase word per bunch. Each accepted sample carries a bunch index or, when the pedestal strobe is high, belongs to the empty reference slot. Over a frame of N turns the block adds up the samples of every bunch and of the pedestal slot, separately for each channel. A frame ends when the N-th pedestal sample is accepted. The block then sweeps once through the bunches, one per clock cycle.

For each bunch the sweep takes the frame averages, subtracts the pedestal averages and forms the squared magnitude of the result. The magnitude is compared with a programmable threshold so that empty or weak bunches are marked. The angle of the corrected vector comes from an arctangent table that covers a single 45-degree octant. Octant folding of the two operands spreads that table over the full circle.

Each result is a 16-bit word. The low twelve bits hold the phase in fractions of a degree, and bit 15 is the low-intensity mark. The ADC front end, the gate timing that produces the bunch index and the consumers of the results are outside the block.

Top module: `bunch_phase_calc`

## Requirements
- R1: While `rstN` is low, and on the first cycle after reset, `resultValid` is low and `resultWord` is zero.
- R2: A frame spans 2^LOG2_AVG pedestal samples. For each bunch and channel, the average is the floor of the frame sum divided by 2^LOG2_AVG, computed the same way for the pedestal slot. The corrected value is the bunch average minus the pedestal average. All sums restart empty for the next frame.
- R3: `resultValid` first rises two clock edges after the edge that accepts the frame's last pedestal sample, with `resultBunch` = 0. The bunches then follow in ascending order on consecutive cycles, with exactly NUM_BUNCH results per frame.
- R4: The phase sits in `resultWord[11:0]`, in units of 2^-PHASE_FRAC degree. It is measured counter-clockwise from the +I axis toward +Q and lies in [0, 360*2^PHASE_FRAC). Bits 14:12 are zero.
- R5: The octant angle is round(atan(k/2^ATAN_BITS) in degrees * 2^PHASE_FRAC), where k = floor(min(|I|,|Q|) * 2^ATAN_BITS / max(|I|,|Q|)). When |Q| > |I| the octant angle is subtracted from 90 degrees. The quadrant then maps that value to x, 180-x, 180+x or 360-x, and 360 degrees wraps to 0. The phase is within one LSB of this value.
- R6: Bit 15 of `resultWord` is 1 when I^2 + Q^2 of the corrected vector is strictly below `intensityThresh`, and 0 when it is equal or above.
- R7: A corrected vector of (0,0) gives phase 0 with bit 15 set, whatever the threshold, including 0.
- R8: Samples of either kind presented during the NUM_BUNCH cycles that follow acceptance of the frame's last pedestal sample are dropped and do not enter the next frame.
- R9: Bunch samples with `bunchIdx` >= NUM_BUNCH are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | A sample pair is present this cycle |
| pedStrobe | input | 1 | The sample belongs to the pedestal slot; bunchIdx is then unused |
| bunchIdx | input | IDX_W | Bunch that the sample belongs to |
| iSample | input | SAMPLE_W | Signed in-phase sample |
| qSample | input | SAMPLE_W | Signed quadrature sample |
| intensityThresh | input | MAG_W | Squared-magnitude threshold for the low-intensity mark |
| resultValid | output | 1 | A result word is present |
| resultBunch | output | IDX_W | Bunch that the result belongs to |
| resultWord | output | 16 | Bit 15 low-intensity mark, bits 11:0 phase |

## Verification
The bench builds the block with five bunches and two-turn averaging, keeping the default sample width, table size and phase scaling. With five bunches the index field has three out-of-range codes. Short frames let samples with odd sums test the floor rounding of negative averages. Frames are cheap, so the bench can step a vector through the full circle in 5-degree steps, add random full-range frames, and hit exact threshold equality, the zero vector, the axes and the diagonals. One frame injects traffic during the sweep, to show that this traffic never reaches the following frame.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic accBunch;   // add the current sample into its bunch sums
    logic accPed;     // add the current sample into the pedestal sums
    logic slotValid;  // a sweep slot is active this cycle
    logic lastSlot;   // the active slot is the final bunch
  } ctrlStrobes_t;

  // Octant arctangent entry, computed in 2^-28 fixed point.
  // Returns round(atan(k / 2^tBits) * 180/pi * 2^fBits).
  function automatic int atanCode(input int k, input int tBits, input int fBits);
    longint one;
    longint x;
    longint y;
    longint y2;
    longint p;
    longint sum;
    longint off;
    longint term;
    longint rad;
    longint code;
    one = longint'(1) << 28;
    x = (longint'(k) << 28) >>> tBits;
    // Above tan(22.5 deg), shift the argument around pi/4 to speed up the series.
    if (x * 1000 > one * 414) begin
      y = ((x - one) * one) / (x + one);
      off = 64'sd210828714;
    end else begin
      y = x;
      off = 0;
    end
    y2 = (y * y) / one;
    p = y;
    sum = 0;
    for (int n = 0; n < 20; n++) begin
      term = p / longint'(2 * n + 1);
      if (n[0]) sum = sum - term;
      else sum = sum + term;
      p = (p * y2) / one;
    end
    rad = sum + off;
    code = (rad * 64'sd60078979 * (longint'(1) << fBits) + (longint'(1) << 47)) >>> 48;
    return int'(code);
  endfunction

endpackage

// File: rtl/bpc_ctrl.sv
module bpc_ctrl #(
  parameter int NUM_BUNCH = 36,
  parameter int LOG2_AVG  = 7,
  parameter int IDX_W     = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic                  pedStrobe,
  input  logic [IDX_W-1:0]      bunchIdx,
  output bpc_pkg::ctrlStrobes_t st,
  output logic [IDX_W-1:0]      slotIdx
);

  localparam int TURN_W = (LOG2_AVG > 0) ? LOG2_AVG : 1;
  localparam logic [TURN_W-1:0] LAST_TURN = TURN_W'((1 << LOG2_AVG) - 1);
  localparam logic [IDX_W-1:0]  LAST_SLOT = IDX_W'(NUM_BUNCH - 1);
  localparam logic [IDX_W:0]    BUNCH_LIM = (IDX_W + 1)'(NUM_BUNCH);

  logic              sweeping;
  logic [TURN_W-1:0] turnCnt;

  always_comb begin
    st.accBunch  = sampleValid && !pedStrobe && !sweeping && ({1'b0, bunchIdx} < BUNCH_LIM);
    st.accPed    = sampleValid && pedStrobe && !sweeping;
    st.slotValid = sweeping;
    st.lastSlot  = sweeping && (slotIdx == LAST_SLOT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sweeping <= 1'b0;
      turnCnt  <= '0;
      slotIdx  <= '0;
    end else begin
      if (st.accPed) begin
        if (turnCnt == LAST_TURN) begin
          turnCnt  <= '0;
          sweeping <= 1'b1;
          slotIdx  <= '0;
        end else begin
          turnCnt <= turnCnt + 1'b1;
        end
      end
      if (sweeping) begin
        if (slotIdx == LAST_SLOT) sweeping <= 1'b0;
        else slotIdx <= slotIdx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/bpc_datapath.sv
module bpc_datapath #(
  parameter int NUM_BUNCH  = 36,
  parameter int SAMPLE_W   = 10,
  parameter int LOG2_AVG   = 7,
  parameter int ATAN_BITS  = 6,
  parameter int PHASE_FRAC = 3,
  parameter int PHASE_W    = 12,
  parameter int IDX_W      = 6,
  parameter int MAG_W      = 21
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bpc_pkg::ctrlStrobes_t      st,
  input  logic [IDX_W-1:0]           slotIdx,
  input  logic [IDX_W-1:0]           bunchIdx,
  input  logic signed [SAMPLE_W-1:0] iSample,
  input  logic signed [SAMPLE_W-1:0] qSample,
  input  logic [MAG_W-1:0]           intensityThresh,
  output logic                       resultValid,
  output logic [IDX_W-1:0]           resultBunch,
  output logic [15:0]                resultWord
);

  localparam int ACC_W = SAMPLE_W + LOG2_AVG;
  localparam int DIF_W = SAMPLE_W + 1;
  localparam int TBL_N = (1 << ATAN_BITS) + 1;
  localparam int K_W   = ATAN_BITS + 1;
  localparam int NUM_W = SAMPLE_W + ATAN_BITS;
  localparam int PAD_W = 15 - PHASE_W;
  localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(90 << PHASE_FRAC);
  localparam logic [PHASE_W-1:0] HALF    = PHASE_W'(180 << PHASE_FRAC);
  localparam logic [PHASE_W-1:0] FULL    = PHASE_W'(360 << PHASE_FRAC);

  // ---------------- accumulation ----------------
  logic signed [ACC_W-1:0] accI [NUM_BUNCH];
  logic signed [ACC_W-1:0] accQ [NUM_BUNCH];
  logic signed [ACC_W-1:0] pedI;
  logic signed [ACC_W-1:0] pedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BUNCH; b++) begin
        accI[b] <= '0;
        accQ[b] <= '0;
      end
    end else begin
      for (int b = 0; b < NUM_BUNCH; b++) begin
        if (st.accBunch && bunchIdx == IDX_W'(b)) begin
          accI[b] <= accI[b] + ACC_W'(iSample);
          accQ[b] <= accQ[b] + ACC_W'(qSample);
        end else if (st.slotValid && slotIdx == IDX_W'(b)) begin
          accI[b] <= '0;
          accQ[b] <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pedI <= '0;
      pedQ <= '0;
    end else if (st.accPed) begin
      pedI <= pedI + ACC_W'(iSample);
      pedQ <= pedQ + ACC_W'(qSample);
    end else if (st.lastSlot) begin
      pedI <= '0;
      pedQ <= '0;
    end
  end

  // ---------------- stage 1: averages and pedestal removal ----------------
  logic signed [ACC_W-1:0]    selI, selQ;
  logic signed [SAMPLE_W-1:0] avgI, avgQ, pedAvgI, pedAvgQ;
  logic signed [DIF_W-1:0]    difI, difQ;

  always_comb begin
    selI    = accI[slotIdx];
    selQ    = accQ[slotIdx];
    avgI    = SAMPLE_W'(selI >>> LOG2_AVG);
    avgQ    = SAMPLE_W'(selQ >>> LOG2_AVG);
    pedAvgI = SAMPLE_W'(pedI >>> LOG2_AVG);
    pedAvgQ = SAMPLE_W'(pedQ >>> LOG2_AVG);
    difI    = DIF_W'(avgI) - DIF_W'(pedAvgI);
    difQ    = DIF_W'(avgQ) - DIF_W'(pedAvgQ);
  end

  logic                    s1Valid;
  logic [IDX_W-1:0]        s1Idx;
  logic signed [DIF_W-1:0] s1I, s1Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Idx   <= '0;
      s1I     <= '0;
      s1Q     <= '0;
    end else begin
      s1Valid <= st.slotValid;
      if (st.slotValid) begin
        s1Idx <= slotIdx;
        s1I   <= difI;
        s1Q   <= difQ;
      end
    end
  end

  // ---------------- octant arctangent table ----------------
  logic [PHASE_W-1:0] atanLut [TBL_N];
  for (genvar k = 0; k < TBL_N; k++) begin : g_lut
    localparam int CODE = bpc_pkg::atanCode(k, ATAN_BITS, PHASE_FRAC);
    assign atanLut[k] = PHASE_W'(CODE);
  end

  // ---------------- stage 2: magnitude, folding, angle ----------------
  logic [SAMPLE_W-1:0] absI, absQ, mx, mn;
  logic                swapped, negI, negQ, zeroVec, flagNext;
  logic [NUM_W-1:0]    numer, quot;
  logic [K_W-1:0]      kIdx;
  logic [PHASE_W-1:0]  tblVal, base, phaseNext;
  logic [MAG_W-1:0]    extI, extQ, sq;

  always_comb begin
    negI    = s1I[DIF_W-1];
    negQ    = s1Q[DIF_W-1];
    absI    = negI ? SAMPLE_W'(-s1I) : SAMPLE_W'(s1I);
    absQ    = negQ ? SAMPLE_W'(-s1Q) : SAMPLE_W'(s1Q);
    zeroVec = (absI == '0) && (absQ == '0);
    swapped = absQ > absI;
    mx      = swapped ? absQ : absI;
    mn      = swapped ? absI : absQ;
    numer   = {mn, ATAN_BITS'(0)};
    quot    = (mx == '0) ? '0 : numer / NUM_W'(mx);
    kIdx    = K_W'(quot);
    tblVal  = atanLut[kIdx];
    base    = swapped ? QUARTER - tblVal : tblVal;
    unique case ({negI, negQ})
      2'b00:   phaseNext = base;
      2'b10:   phaseNext = HALF - base;
      2'b11:   phaseNext = HALF + base;
      default: phaseNext = (base == '0) ? '0 : FULL - base;
    endcase
    extI     = MAG_W'(absI);
    extQ     = MAG_W'(absQ);
    sq       = extI * extI + extQ * extQ;
    flagNext = zeroVec || (sq < intensityThresh);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultBunch <= '0;
      resultWord  <= '0;
    end else begin
      resultValid <= s1Valid;
      if (s1Valid) begin
        resultBunch <= s1Idx;
        resultWord  <= {flagNext, PAD_W'(0), phaseNext};
      end
    end
  end

endmodule

// File: rtl/bunch_phase_calc.sv
module bunch_phase_calc #(
  parameter int NUM_BUNCH  = 36,
  parameter int SAMPLE_W   = 10,
  parameter int LOG2_AVG   = 7,
  parameter int ATAN_BITS  = 6,
  parameter int PHASE_FRAC = 3,
  parameter int PHASE_W    = 12,
  parameter int IDX_W      = $clog2(NUM_BUNCH),
  parameter int MAG_W      = 2 * SAMPLE_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic                       pedStrobe,
  input  logic [IDX_W-1:0]           bunchIdx,
  input  logic signed [SAMPLE_W-1:0] iSample,
  input  logic signed [SAMPLE_W-1:0] qSample,
  input  logic [MAG_W-1:0]           intensityThresh,
  output logic                       resultValid,
  output logic [IDX_W-1:0]           resultBunch,
  output logic [15:0]                resultWord
);

  bpc_pkg::ctrlStrobes_t st;
  logic [IDX_W-1:0]      slotIdx;

  bpc_ctrl #(
    .NUM_BUNCH(NUM_BUNCH),
    .LOG2_AVG (LOG2_AVG),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .pedStrobe  (pedStrobe),
    .bunchIdx   (bunchIdx),
    .st         (st),
    .slotIdx    (slotIdx)
  );

  bpc_datapath #(
    .NUM_BUNCH (NUM_BUNCH),
    .SAMPLE_W  (SAMPLE_W),
    .LOG2_AVG  (LOG2_AVG),
    .ATAN_BITS (ATAN_BITS),
    .PHASE_FRAC(PHASE_FRAC),
    .PHASE_W   (PHASE_W),
    .IDX_W     (IDX_W),
    .MAG_W     (MAG_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .st             (st),
    .slotIdx        (slotIdx),
    .bunchIdx       (bunchIdx),
    .iSample        (iSample),
    .qSample        (qSample),
    .intensityThresh(intensityThresh),
    .resultValid    (resultValid),
    .resultBunch    (resultBunch),
    .resultWord     (resultWord)
  );

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int NUM_BUNCH  = 36,
  parameter int PHASE_FRAC = 3,
  parameter int PHASE_W    = 12,
  parameter int IDX_W      = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             resultValid,
  input logic [IDX_W-1:0] resultBunch,
  input logic [15:0]      resultWord
);

  localparam logic [IDX_W-1:0]   LAST_B = IDX_W'(NUM_BUNCH - 1);
  localparam logic [PHASE_W-1:0] FULL   = PHASE_W'(360 << PHASE_FRAC);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!resultValid && resultWord == 16'h0000));

  // R3
  first_bunch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> resultBunch == '0);

  // R3
  bunch_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultBunch != LAST_B) |=>
      (resultValid && resultBunch == IDX_W'($past(resultBunch) + 1'b1)));

  // R3
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && resultBunch == LAST_B) |=> !resultValid);

  // R4
  phase_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (resultWord[PHASE_W-1:0] < FULL && resultWord[14:PHASE_W] == '0));

  // R9
  bunch_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> resultBunch <= LAST_B);

endmodule

bind bunch_phase_calc bpc_checker #(
  .NUM_BUNCH (NUM_BUNCH),
  .PHASE_FRAC(PHASE_FRAC),
  .PHASE_W   (PHASE_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .resultValid(resultValid),
  .resultBunch(resultBunch),
  .resultWord (resultWord)
);

// File: tb/bunch_phase_calc_tb.sv
module bunch_phase_calc_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB    = 5;
  localparam int LOG2N = 1;
  localparam int NTURN = 1 << LOG2N;
  localparam int SW    = 10;
  localparam int TB    = 6;
  localparam int FB    = 3;
  localparam int PW    = 12;
  localparam int IDXW  = $clog2(NB);
  localparam int MAGW  = 2 * SW + 1;
  localparam int QUART = 90 << FB;
  localparam int HALF  = 180 << FB;
  localparam int FULL  = 360 << FB;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 sampleValid = 1'b0;
  logic                 pedStrobe = 1'b0;
  logic [IDXW-1:0]      bunchIdx = '0;
  logic signed [SW-1:0] iSample = '0;
  logic signed [SW-1:0] qSample = '0;
  logic [MAGW-1:0]      thresh = '0;
  logic                 resultValid;
  logic [IDXW-1:0]      resultBunch;
  logic [15:0]          resultWord;

  bunch_phase_calc #(
    .NUM_BUNCH(NB), .SAMPLE_W(SW), .LOG2_AVG(LOG2N),
    .ATAN_BITS(TB), .PHASE_FRAC(FB), .PHASE_W(PW)
  ) u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .pedStrobe(pedStrobe),
    .bunchIdx(bunchIdx), .iSample(iSample), .qSample(qSample),
    .intensityThresh(thresh), .resultValid(resultValid),
    .resultBunch(resultBunch), .resultWord(resultWord)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0;
  int misses = 0;
  int sumI [NB];
  int sumQ [NB];
  int pedSI, pedSQ;
  int fI [NTURN][NB];
  int fQ [NTURN][NB];
  int fPI [NTURN];
  int fPQ [NTURN];
  logic [15:0] gotWord [NB];
  int gotCnt;

  always @(negedge clk) begin
    if (rstN && resultValid && int'(resultBunch) < NB) begin
      gotWord[resultBunch] = resultWord;
      gotCnt++;
    end
  end

  task automatic note(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int floorAvg(input int s);
    int q;
    q = s / NTURN;
    if ((s % NTURN) != 0 && s < 0) q = q - 1;
    return q;
  endfunction

  function automatic int expPhase(input int dI, input int dQ);
    int ax, ay, mx, mn, k, a, b, r;
    bit swp;
    real deg;
    if (dI == 0 && dQ == 0) return 0;
    ax = (dI < 0) ? -dI : dI;
    ay = (dQ < 0) ? -dQ : dQ;
    swp = ay > ax;
    mx = swp ? ay : ax;
    mn = swp ? ax : ay;
    k = (mn * (1 << TB)) / mx;
    deg = $atan(real'(k) / real'(1 << TB)) * 180.0 / 3.14159265358979;
    a = $rtoi(deg * real'(1 << FB) + 0.5);
    b = swp ? QUART - a : a;
    if (dI >= 0 && dQ >= 0) r = b;
    else if (dI < 0 && dQ >= 0) r = HALF - b;
    else if (dI < 0) r = HALF + b;
    else r = FULL - b;
    if (r == FULL) r = 0;
    return r;
  endfunction

  task automatic drive(input bit ped, input int idx, input int i, input int q, input bit counted);
    @(negedge clk);
    sampleValid = 1'b1;
    pedStrobe = ped;
    bunchIdx = IDXW'(idx);
    iSample = SW'(i);
    qSample = SW'(q);
    if (counted) begin
      if (ped) begin
        pedSI += i;
        pedSQ += q;
      end else begin
        sumI[idx] += i;
        sumQ[idx] += q;
      end
    end
    @(negedge clk);
    sampleValid = 1'b0;
    pedStrobe = 1'b0;
  endtask

  // Plays one frame from fI/fQ/fPI/fPQ and checks the results.
  task automatic playFrame(input bit inject, input bit stray, input string tag);
    int dI, dQ, sq, ep, gp, diff;
    bit ef;
    for (int b = 0; b < NB; b++) begin
      sumI[b] = 0;
      sumQ[b] = 0;
    end
    pedSI = 0;
    pedSQ = 0;
    gotCnt = 0;
    for (int t = 0; t < NTURN; t++) begin
      for (int b = 0; b < NB; b++) begin
        drive(1'b0, b, fI[t][b], fQ[t][b], 1'b1);
        if (stray && t == 0 && b == 1) begin
          // R9: indices beyond the last bunch must be dropped
          for (int x = NB; x < (1 << IDXW); x++) drive(1'b0, x, 511, -512, 1'b0);
        end
      end
      drive(1'b1, 0, fPI[t], fPQ[t], 1'b1);
    end
    // Now at the falling edge just after the edge that took the last pedestal.
    for (int c = 0; c < NB + 4; c++) begin
      if (c < 2) note(!resultValid, "R3 latency (valid early)", int'(resultValid), 0);
      if (c == 2) begin
        note(resultValid, "R3 latency (valid on time)", int'(resultValid), 1);
        note(resultBunch == '0, "R3 first bunch", int'(resultBunch), 0);
      end
      if (inject && c < NB) begin
        // R8: traffic during the sweep must be dropped
        sampleValid = 1'b1;
        pedStrobe = (c == 1);
        bunchIdx = IDXW'(c % NB);
        iSample = SW'(-512 + c);
        qSample = SW'(511);
      end else begin
        sampleValid = 1'b0;
        pedStrobe = 1'b0;
      end
      @(negedge clk);
    end
    note(gotCnt == NB, "R3 result count", gotCnt, NB);
    for (int b = 0; b < NB; b++) begin
      dI = floorAvg(sumI[b]) - floorAvg(pedSI);
      dQ = floorAvg(sumQ[b]) - floorAvg(pedSQ);
      sq = dI * dI + dQ * dQ;
      ef = (dI == 0 && dQ == 0) || (sq < int'(thresh));
      ep = expPhase(dI, dQ);
      gp = int'(gotWord[b][PW-1:0]);
      diff = gp - ep;
      if (diff > FULL / 2) diff -= FULL;
      if (diff < -FULL / 2) diff += FULL;
      if (dI == 0 && dQ == 0)
        note(gp == 0 && gotWord[b][15], $sformatf("%s R7 zero vector bunch %0d", tag, b),
             int'(gotWord[b]), 16'h8000);
      note(gotWord[b][15] == ef, $sformatf("%s R6 flag bunch %0d (d=%0d,%0d)", tag, b, dI, dQ),
           int'(gotWord[b][15]), int'(ef));
      note(diff >= -1 && diff <= 1,
           $sformatf("%s R2 R5 phase bunch %0d (d=%0d,%0d)", tag, b, dI, dQ), gp, ep);
      note(gotWord[b][14:PW] == '0, $sformatf("%s R4 pad bits bunch %0d", tag, b),
           int'(gotWord[b][14:PW]), 0);
    end
  endtask

  task automatic fillRandom();
    for (int t = 0; t < NTURN; t++) begin
      for (int b = 0; b < NB; b++) begin
        fI[t][b] = int'($urandom_range(1023)) - 512;
        fQ[t][b] = int'($urandom_range(1023)) - 512;
      end
      fPI[t] = int'($urandom_range(1023)) - 512;
      fPQ[t] = int'($urandom_range(1023)) - 512;
    end
  endtask

  task automatic fillCorner(input int vi[NB], input int vq[NB]);
    for (int t = 0; t < NTURN; t++) begin
      for (int b = 0; b < NB; b++) begin
        fI[t][b] = vi[b];
        fQ[t][b] = vq[b];
      end
      fPI[t] = 10;
      fPQ[t] = -20;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    note(!resultValid && resultWord == 16'h0, "R1 during reset", int'(resultWord), 0);
    rstN = 1'b1;
    @(negedge clk);
    note(!resultValid && resultWord == 16'h0, "R1 after reset", int'(resultWord), 0);

    // Full-circle sweep in 5-degree steps with varying radius and odd sums.
    thresh = MAGW'(40000);
    for (int f = 0; f < 72 / NB + 1; f++) begin
      for (int b = 0; b < NB; b++) begin
        real th;
        int rad, bi, bq;
        th = real'(((f * NB + b) % 72) * 5) * 3.14159265358979 / 180.0;
        rad = 150 + (f * 37 + b * 53) % 300;
        bi = int'(real'(rad) * $cos(th));
        bq = int'(real'(rad) * $sin(th));
        fI[0][b] = bi + (f % 7) - 3;
        fI[1][b] = bi + (f % 7) - 2;
        fQ[0][b] = bq + 2 - (f % 5);
        fQ[1][b] = bq + 3 - (f % 5);
      end
      fPI[0] = (f % 7) - 3;
      fPI[1] = (f % 7) - 2;
      fPQ[0] = 2 - (f % 5);
      fPQ[1] = 3 - (f % 5);
      playFrame(1'b0, 1'b0, "sweep");
    end

    // Random full-range frames.
    for (int f = 0; f < 20; f++) begin
      thresh = MAGW'($urandom_range(1 << 20));
      fillRandom();
      playFrame(1'b0, 1'b0, "random");
    end

    // Threshold equality, zero vector, diagonal and axis cases.
    thresh = MAGW'(2500);
    fillCorner('{10, 40, 40, -90, 10}, '{-20, 20, 19, -120, -220});
    playFrame(1'b0, 1'b0, "R6 R7 corners");
    thresh = '0;
    fillCorner('{10, 10, 110, 10, -90}, '{-20, -20, -20, 80, -20});
    playFrame(1'b0, 1'b0, "R7 zero thr");

    // Sweep-time traffic must not leak into the next frame.
    thresh = MAGW'(10000);
    fillRandom();
    playFrame(1'b1, 1'b0, "R8 inject");
    fillRandom();
    playFrame(1'b0, 1'b0, "R8 after");

    // Out-of-range bunch indices.
    fillRandom();
    playFrame(1'b0, 1'b1, "R9 stray");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule